// File: doc/BRIEF.md
# Multichannel Serial Audio Receiver

This block turns an I2S-style serial audio link into a stream of PCM words for a downstream FIFO. The link is a bit clock, a frame clock that marks the left and right slots, and one data line per channel pair. All three link signals are sampled in the system clock domain. Each finished sample leaves as one 32-bit word on a single-cycle push strobe. One to three channel pairs are supported, and samples can be 1 to 24 bits wide.

One frame (a left slot followed by a right slot) forms one collection. Within a collection, all left samples are pushed first and then all right samples. Both groups run in pair order, from data line 0 upwards. A run enable starts capture at the next left-slot boundary. When run is cleared, the collection in flight is allowed to finish before the block goes idle. A busy flag shows when a collection is being captured or pushed.

Top module: `pcmrx_top`

## Requirements
- R1: Data is taken on rising bit-clock edges, most significant bit first. The first bit of a slot arrives one bit clock after the frame-clock edge. Frame clock 0 is the left slot and 1 is the right slot. A sample of width W (the `widthSel` value, 1 to 24) is pushed right-justified: its last received bit is at bit 0, and bits 31 down to W are zero.
- R2: Within one collection, the left samples of all enabled pairs are pushed first, in data-line order 0, 1, 2. The right samples follow in the same line order.
- R3: A `pairSel` value of 1, 2 or 3 enables data lines 0 to `pairSel`-1, giving 2, 4 or 6 pushes per collection. Lines above the enabled count never appear in a pushed word. The pushes of one slot group come on consecutive clocks.
- R4: Capture begins only at a left-slot start that is seen while run is high. A frame whose left slot had already begun when run rose pushes nothing. The first word pushed after a start is therefore a left sample.
- R5: If run is cleared during a collection, that collection is still captured and pushed in full, and no further words are pushed after it.
- R6: `busy` goes high at the first captured bit of a collection. It stays high until the last word of the final collection has been pushed, and it is low whenever the block is idle.
- R7: Slot bits received after the first W bits of a slot have no effect on the pushed word.
- R8: `pairSel` and `widthSel` are sampled when a collection starts. Changing them during that collection does not alter its words.
- R9: During and right after reset, `pushValid` and `busy` are low and `pushData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock from the link (asynchronous) |
| lrclk | input | 1 | Frame clock; 0 selects the left slot, 1 the right slot |
| sdata | input | 3 | Serial data, one line per channel pair |
| run | input | 1 | Capture enable |
| pairSel | input | 2 | Number of enabled channel pairs (1 to 3) |
| widthSel | input | 5 | Sample width in bits (1 to 24) |
| pushValid | output | 1 | One-cycle push strobe for each finished sample |
| pushData | output | 32 | Right-justified, zero-extended sample word |
| busy | output | 1 | Collection being captured or pushed |

## Verification
The link carries distinct per-line patterns, with the padding bits after each sample driven to one. A shifted or untruncated word therefore shows up as a wrong value instead of passing unnoticed. Successive collections use pair counts of one, two and three with widths of 24, 16, 20 and 12. This separates correct grouping and line order from an interleaved order, and correct justification from a fixed width. Further frames raise run midway through a left slot, drop it midway through a captured collection, and change both settings mid-collection. These frames distinguish a clean start and a clean stop, and sampled settings from live ones. A busy check in the right slot of every frame separates captured frames from idle ones.

// File: rtl/pcmrx_pkg.sv
package pcmrx_pkg;
  localparam int PCM_MAX_PAIRS   = 3;
  localparam int PCM_MAX_WIDTH   = 24;
  localparam int PCM_WORD_W      = 32;
  localparam int PCM_SYNC_STAGES = 2;
  localparam int PCM_IDX_W  = (PCM_MAX_PAIRS > 1) ? $clog2(PCM_MAX_PAIRS) : 1;
  localparam int PCM_PSEL_W = $clog2(PCM_MAX_PAIRS + 1);
  localparam int PCM_WSEL_W = $clog2(PCM_MAX_WIDTH + 1);

  // Strobes from control to datapath
  typedef struct packed {
    logic                 restart;    // first bit of a new slot
    logic                 shiftEn;    // append bit to current sample
    logic                 latchHold;  // move finished slot into hold registers
    logic                 pushEn;     // emit one held sample
    logic [PCM_IDX_W-1:0] pushIdx;    // which line to emit
  } pcmStrobe_t;
endpackage

// File: rtl/pcmrx_ctrl.sv
module pcmrx_ctrl
  import pcmrx_pkg::*;
#(
  parameter int SYNC_STAGES = PCM_SYNC_STAGES
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  bclkIn,
  input  logic                  lrclkIn,
  input  logic                  run,
  input  logic [PCM_PSEL_W-1:0] pairSel,
  input  logic [PCM_WSEL_W-1:0] widthSel,
  output pcmStrobe_t            strb,
  output logic                  ctrlBusy
);
  localparam logic [PCM_WSEL_W-1:0] WMAX = PCM_WSEL_W'(PCM_MAX_WIDTH);
  localparam logic [PCM_PSEL_W-1:0] PMAX = PCM_PSEL_W'(PCM_MAX_PAIRS);

  logic [SYNC_STAGES:0]   bSh;
  logic [SYNC_STAGES-1:0] lSh;
  logic bRise, lrNow, newSlot, shiftOk, latchNow;
  logic lrPrev, lrPrev2;
  logic [1:0] primed;
  logic capturing, pushing;
  logic [PCM_WSEL_W-1:0] bitCnt, widthLat, effWidth;
  logic [PCM_PSEL_W-1:0] pairsLat, effPairs;
  logic [PCM_IDX_W-1:0]  pushIdx, pushLast;

  // Link clock synchronizers; bclk carries one extra stage for edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bSh <= '0;
      lSh <= '0;
    end else begin
      bSh <= {bSh[SYNC_STAGES-1:0], bclkIn};
      lSh <= {lSh[SYNC_STAGES-2:0], lrclkIn};
    end
  end

  assign bRise = bSh[SYNC_STAGES-1] & ~bSh[SYNC_STAGES];
  assign lrNow = lSh[SYNC_STAGES-1];

  always_comb begin
    effWidth = widthSel;
    if (widthSel == '0 || widthSel > WMAX) effWidth = WMAX;
    effPairs = pairSel;
    if (pairSel == '0) effPairs = PCM_PSEL_W'(1);
    else if (pairSel > PMAX) effPairs = PMAX;
  end

  // The bit taken at a rise belongs to the slot the frame clock showed at
  // the previous rise (one-bit delay); a change there marks a slot start.
  assign newSlot  = bRise && (primed == 2'd2) && (lrPrev != lrPrev2);
  assign shiftOk  = bRise && !newSlot && (bitCnt < widthLat);
  assign latchNow = newSlot && capturing;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lrPrev    <= 1'b0;
      lrPrev2   <= 1'b0;
      primed    <= '0;
      capturing <= 1'b0;
      bitCnt    <= '0;
      widthLat  <= WMAX;
      pairsLat  <= PCM_PSEL_W'(1);
    end else begin
      if (bRise) begin
        lrPrev  <= lrNow;
        lrPrev2 <= lrPrev;
        if (primed != 2'd2) primed <= primed + 2'd1;
      end
      if (newSlot) begin
        bitCnt <= PCM_WSEL_W'(1);
        if (!lrPrev) begin          // a left slot starts: collection boundary
          capturing <= run;
          if (run) begin
            widthLat <= effWidth;
            pairsLat <= effPairs;
          end
        end
      end else if (shiftOk) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // Push sequencer: walks the enabled lines once per finished slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pushing  <= 1'b0;
      pushIdx  <= '0;
      pushLast <= '0;
    end else if (latchNow) begin
      pushing  <= 1'b1;
      pushIdx  <= '0;
      pushLast <= PCM_IDX_W'(pairsLat - 1'b1);
    end else if (pushing) begin
      if (pushIdx == pushLast) pushing <= 1'b0;
      else pushIdx <= pushIdx + 1'b1;
    end
  end

  assign strb.restart   = newSlot;
  assign strb.shiftEn   = shiftOk;
  assign strb.latchHold = latchNow;
  assign strb.pushEn    = pushing;
  assign strb.pushIdx   = pushIdx;
  assign ctrlBusy       = capturing | pushing;
endmodule

// File: rtl/pcmrx_datapath.sv
module pcmrx_datapath
  import pcmrx_pkg::*;
#(
  parameter int SYNC_STAGES = PCM_SYNC_STAGES
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [PCM_MAX_PAIRS-1:0] sdataIn,
  input  pcmStrobe_t               strb,
  output logic                     pushValid,
  output logic [PCM_WORD_W-1:0]    pushData
);
  logic [PCM_MAX_PAIRS-1:0] dSh [SYNC_STAGES];
  logic [PCM_MAX_PAIRS-1:0] dBit;
  logic [PCM_MAX_WIDTH-1:0] shReg   [PCM_MAX_PAIRS];
  logic [PCM_MAX_WIDTH-1:0] holdArr [PCM_MAX_PAIRS];

  // Same depth as the bit-clock path so a bit lines up with its edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) dSh[s] <= '0;
    end else begin
      dSh[0] <= sdataIn;
      for (int s = 1; s < SYNC_STAGES; s++) dSh[s] <= dSh[s-1];
    end
  end
  assign dBit = dSh[SYNC_STAGES-1];

  for (genvar g = 0; g < PCM_MAX_PAIRS; g++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shReg[g]   <= '0;
        holdArr[g] <= '0;
      end else begin
        if (strb.latchHold) holdArr[g] <= shReg[g];
        if (strb.restart)
          shReg[g] <= {{(PCM_MAX_WIDTH-1){1'b0}}, dBit[g]};
        else if (strb.shiftEn)
          shReg[g] <= {shReg[g][PCM_MAX_WIDTH-2:0], dBit[g]};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pushValid <= 1'b0;
      pushData  <= '0;
    end else begin
      pushValid <= strb.pushEn;
      if (strb.pushEn) pushData <= PCM_WORD_W'(holdArr[strb.pushIdx]);
    end
  end
endmodule

// File: rtl/pcmrx_top.sv
module pcmrx_top
  import pcmrx_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     bclk,
  input  logic                     lrclk,
  input  logic [PCM_MAX_PAIRS-1:0] sdata,
  input  logic                     run,
  input  logic [PCM_PSEL_W-1:0]    pairSel,
  input  logic [PCM_WSEL_W-1:0]    widthSel,
  output logic                     pushValid,
  output logic [PCM_WORD_W-1:0]    pushData,
  output logic                     busy
);
  pcmStrobe_t strb;
  logic ctrlBusy;

  pcmrx_ctrl #(.SYNC_STAGES(PCM_SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .bclkIn(bclk), .lrclkIn(lrclk), .run(run),
    .pairSel(pairSel), .widthSel(widthSel), .strb(strb), .ctrlBusy(ctrlBusy)
  );

  pcmrx_datapath #(.SYNC_STAGES(PCM_SYNC_STAGES)) uData (
    .clk(clk), .rstN(rstN), .sdataIn(sdata), .strb(strb),
    .pushValid(pushValid), .pushData(pushData)
  );

  assign busy = ctrlBusy | pushValid;
endmodule

// File: rtl/pcmrx_chk.sv
module pcmrx_chk
  import pcmrx_pkg::*;
(
  input logic                                clk,
  input logic                                rstN,
  input logic                                run,
  input logic                                pushValid,
  input logic [PCM_WORD_W-PCM_MAX_WIDTH-1:0] pushUpper,
  input logic                                busy
);
  logic [3:0] burstCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) burstCnt <= '0;
    else if (pushValid) burstCnt <= burstCnt + 4'd1;
    else burstCnt <= '0;
  end

  // R1
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> (pushUpper == '0));

  // R3
  burst_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> (burstCnt < 4'(PCM_MAX_PAIRS)));

  // R4
  start_no_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !pushValid);

  // R5
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !busy) |=> !busy);

  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(pushValid));
endmodule

bind pcmrx_top pcmrx_chk uChk (
  .clk(clk), .rstN(rstN), .run(run), .pushValid(pushValid),
  .pushUpper(pushData[pcmrx_pkg::PCM_WORD_W-1:pcmrx_pkg::PCM_MAX_WIDTH]),
  .busy(busy)
);

// File: tb/tb_pcmrx_top.sv
module tb_pcmrx_top;
  localparam int SLOT = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bclk = 1'b0, lrclk = 1'b1, run = 1'b0;
  logic [2:0] sdata = '0;
  logic [1:0] pairSel = 2'd1;
  logic [4:0] widthSel = 5'd24;
  logic pushValid, busy;
  logic [31:0] pushData;

  int vectors = 0;
  int misses = 0;
  logic [31:0] expQ[$];
  string tagQ[$];
  logic [23:0] curL[3], curR[3], prevR[3];
  int prevW = 24;

  always #10 clk = ~clk;

  pcmrx_top dut (
    .clk(clk), .rstN(rstN), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .run(run), .pairSel(pairSel), .widthSel(widthSel),
    .pushValid(pushValid), .pushData(pushData), .busy(busy)
  );

  function automatic logic slotBit(logic [23:0] s, int w, int idx);
    // R7: bits after the sample are driven to one
    return (idx < w) ? s[w-1-idx] : 1'b1;
  endfunction

  function automatic logic [23:0] pat(int n);
    return 24'((n * 32'h9E3779B1) ^ (n << 9) ^ 32'h00A5C3);
  endfunction

  // Reference model: every clock, a push must match the queue front
  always @(negedge clk) begin
    if (rstN && pushValid) begin
      vectors++;
      if (expQ.size() == 0) begin
        misses++;
        $display("FAIL R5 unexpected push: actual %h expected none", pushData);
      end else begin
        if (pushData !== expQ[0]) begin
          misses++;
          $display("FAIL %s push word: actual %h expected %h", tagQ[0], pushData, expQ[0]);
        end
        void'(expQ.pop_front());
        void'(tagQ.pop_front());
      end
    end
  end

  task automatic bitPeriod(logic lrv, logic [2:0] dv);
    @(negedge clk);
    bclk = 1'b0; lrclk = lrv; sdata = dv;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // One frame; r1 applied mid-left, r2 mid-right, wMid/pMid mid-left (-1: none)
  task automatic sendFrame(int w, int np, int r1, int r2, int wMid, int pMid, int seed);
    bit cap;
    logic [31:0] mask;
    for (int k = 0; k < 3; k++) begin
      curL[k] = pat(seed * 7 + k);
      curR[k] = pat(seed * 7 + k + 3);
    end
    widthSel = 5'(w);
    pairSel  = 2'(np);
    cap = run;
    mask = (32'd1 << w) - 32'd1;
    if (cap) begin
      // R1 R2 R3 R8: lefts in line order, then rights, width w
      for (int k = 0; k < np; k++) begin
        expQ.push_back({8'd0, curL[k]} & mask); tagQ.push_back("R1 R2 R3 R8 left");
      end
      for (int k = 0; k < np; k++) begin
        expQ.push_back({8'd0, curR[k]} & mask); tagQ.push_back("R1 R2 R3 R8 right");
      end
    end
    for (int j = 0; j < 2 * SLOT; j++) begin
      logic [2:0] dv;
      int p = j - 1;
      for (int k = 0; k < 3; k++) begin
        if (p < 0) dv[k] = slotBit(prevR[k], prevW, SLOT - 1);
        else if (p < SLOT) dv[k] = slotBit(curL[k], w, p);
        else dv[k] = slotBit(curR[k], w, p - SLOT);
      end
      if (j == SLOT / 2) begin
        if (r1 >= 0) run = r1[0];
        if (wMid >= 0) widthSel = 5'(wMid);
        if (pMid >= 0) pairSel = 2'(pMid);
      end
      if (j == SLOT + SLOT / 2) begin
        vectors++;
        if (busy !== cap) begin
          misses++;
          $display("FAIL R6 busy mid right slot: actual %b expected %b", busy, cap);
        end
        if (r2 >= 0) run = r2[0];
      end
      bitPeriod(j < SLOT ? 1'b0 : 1'b1, dv);
    end
    for (int k = 0; k < 3; k++) prevR[k] = curR[k];
    prevW = w;
  endtask

  initial begin
    for (int k = 0; k < 3; k++) prevR[k] = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    vectors++;
    if (pushValid !== 1'b0 || busy !== 1'b0 || pushData !== 32'd0) begin
      misses++;
      $display("FAIL R9 reset outputs: actual %b %b %h expected 0 0 0", pushValid, busy, pushData);
    end
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R4: run rises mid-left; this frame must push nothing
    sendFrame(24, 1, 1, -1, -1, -1, 1);
    sendFrame(24, 1, -1, -1, -1, -1, 2);
    sendFrame(16, 2, -1, -1, -1, -1, 3);
    // R8: settings changed mid-collection
    sendFrame(20, 3, -1, -1, 8, 1, 4);
    // R5: run cleared mid-left; collection still completes
    sendFrame(24, 3, 0, -1, -1, -1, 5);
    sendFrame(24, 3, -1, 1, -1, -1, 6);
    sendFrame(12, 2, -1, 0, -1, -1, 7);
    sendFrame(24, 3, -1, -1, -1, -1, 8);
    sendFrame(24, 3, -1, -1, -1, -1, 9);
    repeat (20) @(negedge clk);
    // R5 R6: everything drained, block idle
    vectors++;
    if (expQ.size() != 0 || busy !== 1'b0) begin
      misses++;
      $display("FAIL R5 R6 end state: actual pending %0d busy %b expected 0 0", expQ.size(), busy);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule